// File: doc/BRIEF.md
# Dual-Mode Digital Phase Comparator

This block is the phase-detector stage of a phase-locked loop, modelled synchronously. It is oversampled by a fast system clock. Two signals feed it: a reference input `sig_a` and a feedback input `sig_b` from the divided oscillator. Both inputs go through a multi-flop synchronizer and an edge detector. The same conditioned pair then feeds two comparators that run side by side. The loop designer takes the error output of whichever comparator suits the application.

The first comparator is an exclusive-OR detector. With square waves on both inputs it settles the loop at a quarter-period offset at the centre frequency. That offset moves toward zero and toward a half period at the edges of the lock range. The detector can also lock onto harmonics. Its output is a single registered error bit.

The second comparator is a rising-edge, three-state phase-frequency detector. It ignores duty cycle and drives the loop toward coincident rising edges. Its state machine has four states:

| State | Meaning | Output |
|---|---|---|
| `PD_IDLE` | no edge pending | drive off, lock flag high |
| `PD_LEAD_A` | reference edge pending | driven high |
| `PD_LEAD_B` | feedback edge pending | driven low |
| `PD_CLEAR` | both edges seen | drive off, lock flag low, lasts one cycle |

The transitions are as follows:
- An A-only edge moves `PD_IDLE` to `PD_LEAD_A`.
- A B-only edge moves `PD_IDLE` to `PD_LEAD_B`.
- Coincident edges keep the machine in `PD_IDLE`.
- A B edge moves `PD_LEAD_A` to `PD_CLEAR`. An A edge moves `PD_LEAD_B` to `PD_CLEAR`.
- `PD_CLEAR` always returns to `PD_IDLE`.
- Any other case holds the current state.

When the reference is silent, the repeated feedback edges keep the output driven low. This pulls the oscillator toward its minimum frequency.

Top module: `pdc_dual_detector`

## Requirements
- R1: `xor_err` equals the exclusive OR of `sig_a` and `sig_b`, seen three clock edges after the inputs change.
- R2: From idle, a rising edge on `sig_a` alone gives `pfd_oe`=1, `pfd_drive`=1 and `lock_flag`=0.
- R3: From idle, a rising edge on `sig_b` alone gives `pfd_oe`=1, `pfd_drive`=0 and `lock_flag`=0.
- R4: When the second input's rising edge arrives, the outputs show exactly one cycle of `pfd_oe`=0 and `lock_flag`=0. After that they return to idle: `pfd_oe`=0 and `lock_flag`=1.
- R5: Rising edges on both inputs in the same sample leave the detector idle, with `lock_flag` high throughout.
- R6: Falling edges, and further rising edges on the input that already leads, do not change the comparator-2 outputs. The duty cycle of the inputs therefore has no effect.
- R7: With `sig_a` held low and `sig_b` toggling, the output stays driven low (`pfd_oe`=1, `pfd_drive`=0) once the first `sig_b` edge has passed.
- R8: A synchronous active-high `rst` puts the detector in idle (`pfd_oe`=0, `lock_flag`=1) and clears `xor_err` at the next clock edge, whatever state it was in.
- R9: A comparator-2 output reacts three clock edges after the input change that caused it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system sampling clock |
| rst | input | 1 | synchronous active-high reset |
| sig_a | input | 1 | reference signal input |
| sig_b | input | 1 | feedback signal input |
| xor_err | output | 1 | exclusive-OR comparator error bit |
| pfd_drive | output | 1 | edge comparator drive value, meaningful when `pfd_oe` is 1 |
| pfd_oe | output | 1 | edge comparator output enable; 0 models the disconnected state |
| lock_flag | output | 1 | high while no edge is pending |

## Verification
Every result trails its stimulus by three clock edges: two synchronizer flops, then the state or XOR register. The bench changes the inputs on falling clock edges. It samples on the falling edge before each change, and compares the outputs against the input history from three steps earlier. The bench sweeps every pair of A and B rising-edge times in a six-step window. From each pair's edge times it predicts when the lead state starts, the single clear cycle and the return to idle. Further sequences cover extra edges while one input leads, a silent reference, and a reset from a driven state. Each of these is sampled one step after its effect is due.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    // States of the rising-edge phase-frequency detector
    typedef enum logic [1:0] {
        PD_IDLE   = 2'b00,
        PD_LEAD_A = 2'b01,
        PD_LEAD_B = 2'b10,
        PD_CLEAR  = 2'b11
    } pd_state_e;

    localparam int unsigned PDC_DEF_SYNC = 2;

endpackage

// File: rtl/pdc_input_stage.sv
module pdc_input_stage #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic level,
    output logic rise
);

    localparam int unsigned MSB = SYNC_STAGES - 1;

    logic [MSB:0] chain;
    logic         level_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= raw_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[MSB-1:0], raw_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) level_prev <= 1'b0;
        else     level_prev <= chain[MSB];
    end

    assign level = chain[MSB];
    assign rise  = chain[MSB] & ~level_prev;

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R6

endmodule

// File: rtl/pdc_xor_cmp.sv
module pdc_xor_cmp (
    input  logic clk,
    input  logic rst,
    input  logic a_lvl,
    input  logic b_lvl,
    output logic err
);

    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= a_lvl ^ b_lvl;
    end

    assign err = err_q;

    AST_XOR_DIFF: assert property (@(posedge clk) disable iff (rst)
        (a_lvl != b_lvl) |=> err); // R1
    AST_XOR_SAME: assert property (@(posedge clk) disable iff (rst)
        (a_lvl == b_lvl) |=> !err); // R1

endmodule

// File: rtl/pdc_edge_fsm.sv
module pdc_edge_fsm
    import pdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise_a,
    input  logic rise_b,
    output logic drive,
    output logic oe,
    output logic lock
);

    pd_state_e state, state_nx;

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            PD_IDLE: begin
                if (rise_a && !rise_b)      state_nx = PD_LEAD_A;
                else if (rise_b && !rise_a) state_nx = PD_LEAD_B;
                else                        state_nx = PD_IDLE;
            end
            PD_LEAD_A: if (rise_b) state_nx = PD_CLEAR;
            PD_LEAD_B: if (rise_a) state_nx = PD_CLEAR;
            PD_CLEAR:  state_nx = PD_IDLE;
            default:   state_nx = PD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= PD_IDLE;
        else     state <= state_nx;
    end

    // output decode
    always_comb begin
        drive = 1'b0;
        oe    = 1'b0;
        lock  = 1'b0;
        unique case (state)
            PD_IDLE:   lock = 1'b1;
            PD_LEAD_A: begin oe = 1'b1; drive = 1'b1; end
            PD_LEAD_B: begin oe = 1'b1; drive = 1'b0; end
            PD_CLEAR:  lock = 1'b0;
            default:   lock = 1'b0;
        endcase
    end

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_IDLE: assert (lock && !oe); // R8
        end
    end

    AST_A_LEADS: assert property (@(posedge clk) disable iff (rst)
        (state == PD_IDLE && rise_a && !rise_b) |=> (oe && drive && !lock)); // R2
    AST_B_LEADS: assert property (@(posedge clk) disable iff (rst)
        (state == PD_IDLE && rise_b && !rise_a) |=> (oe && !drive && !lock)); // R3
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (rst)
        (state == PD_CLEAR) |=> (lock && !oe)); // R4
    AST_COINCIDENT: assert property (@(posedge clk) disable iff (rst)
        (state == PD_IDLE && rise_a && rise_b) |=> lock); // R5
    AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        (state == PD_LEAD_A && !rise_b) |=> (oe && drive)); // R6
    AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        (state == PD_LEAD_B && !rise_a) |=> (oe && !drive)); // R7
    AST_LOCK_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        lock |-> !oe); // R4

endmodule

// File: rtl/pdc_dual_detector.sv
module pdc_dual_detector #(
    parameter int unsigned SYNC_STAGES = pdc_pkg::PDC_DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_a,
    input  logic sig_b,
    output logic xor_err,
    output logic pfd_drive,
    output logic pfd_oe,
    output logic lock_flag
);

    logic a_lvl, a_rise, b_lvl, b_rise;

    pdc_input_stage #(.SYNC_STAGES(SYNC_STAGES)) u_in_a (
        .clk(clk), .rst(rst), .raw_in(sig_a), .level(a_lvl), .rise(a_rise)
    );

    pdc_input_stage #(.SYNC_STAGES(SYNC_STAGES)) u_in_b (
        .clk(clk), .rst(rst), .raw_in(sig_b), .level(b_lvl), .rise(b_rise)
    );

    pdc_xor_cmp u_xor (
        .clk(clk), .rst(rst), .a_lvl(a_lvl), .b_lvl(b_lvl), .err(xor_err)
    );

    pdc_edge_fsm u_pfd (
        .clk(clk), .rst(rst), .rise_a(a_rise), .rise_b(b_rise),
        .drive(pfd_drive), .oe(pfd_oe), .lock(lock_flag)
    );

    AST_DRIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pfd_oe |-> !pfd_drive); // R4

endmodule

// File: tb/tb_pdc_dual_detector.sv
module tb_pdc_dual_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_a = 1'b0;
    logic sig_b = 1'b0;
    logic xor_err, pfd_drive, pfd_oe, lock_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pdc_dual_detector dut (
        .clk(clk), .rst(rst), .sig_a(sig_a), .sig_b(sig_b),
        .xor_err(xor_err), .pfd_drive(pfd_drive), .pfd_oe(pfd_oe),
        .lock_flag(lock_flag)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // code: 0 idle, 1 A leads, 2 B leads, 3 clear cycle
    task automatic expect_pfd(input string req, input int code);
        logic e_oe;
        e_oe = (code == 1 || code == 2);
        check(req, "pfd_oe", pfd_oe, e_oe);
        if (e_oe) check(req, "pfd_drive", pfd_drive, code == 1);
        check(req, "lock_flag", lock_flag, code == 0);
    endtask

    task automatic settle_low();
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            expect_pfd("R6", 0);
            sig_a = 1'b0;
            sig_b = 1'b0;
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_pfd("R8", 0);
        check("R8", "xor_err", xor_err, 1'b0);
        rst = 1'b0;

        // sweep of every pair of rising-edge times
        for (int ta = 0; ta < 6; ta++) begin
            for (int tb = 0; tb < 6; tb++) begin
                for (int s = 0; s < 15; s++) begin
                    int ea, eb, code;
                    string req;
                    @(negedge clk);
                    ea = ta + 3;
                    eb = tb + 3;
                    if (ta == tb) code = 0;
                    else if (ta < tb) code = (s < ea) ? 0 : (s < eb) ? 1 : (s == eb) ? 3 : 0;
                    else              code = (s < eb) ? 0 : (s < ea) ? 2 : (s == ea) ? 3 : 0;
                    if (ta == tb)     req = "R5";
                    else if (code == 1) req = "R2";
                    else if (code == 2) req = "R3";
                    else if (code == 3) req = "R4";
                    else req = "R9";
                    expect_pfd(req, code);
                    check("R1", "xor_err", xor_err, ((s - 3) >= ta) ^ ((s - 3) >= tb));
                    sig_a = (s >= ta);
                    sig_b = (s >= tb);
                end
                settle_low();
            end
        end

        // extra A edges and a falling edge while A leads
        for (int s = 0; s < 16; s++) begin
            int code;
            @(negedge clk);
            code = (s < 3) ? 0 : (s <= 10) ? 1 : (s == 11) ? 3 : 0;
            expect_pfd("R6", code);
            sig_a = (s < 2) || (s >= 4);
            sig_b = (s >= 8);
        end
        settle_low();

        // silent reference, feedback toggling
        for (int s = 0; s < 17; s++) begin
            @(negedge clk);
            expect_pfd("R7", (s < 3) ? 0 : 2);
            check("R1", "xor_err", xor_err, (s >= 3) && (((s - 3) % 4) < 2));
            sig_a = 1'b0;
            sig_b = ((s % 4) < 2);
        end
        rst = 1'b1;
        @(negedge clk);
        expect_pfd("R8", 0);
        check("R8", "xor_err", xor_err, 1'b0);
        rst = 1'b0;
        sig_b = 1'b0;
        settle_low();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule